// File: doc/BRIEF.md
# Widening Signed Integer Outer-Product Tile Accumulator

The block multiplies a column vector by a row vector and adds the resulting matrix into one selected accumulator tile held in local registers. Each source vector is one packed word of `VL_WORDS` 32-bit lanes, with a default of four. Every operation widens. In the byte mode, four adjacent signed bytes of a lane are multiplied pairwise and the four products are summed into one 32-bit cell. In the two halfword modes, two adjacent signed 16-bit values are multiplied pairwise and the two products are summed into one 32-bit or one 64-bit cell.

The accumulator storage is a single array of `4*VL_WORDS` lines of `32*VL_WORDS` bits. Two typed views share it: four tiles of 32-bit cells, or eight tiles of 64-bit cells. A tile with 32-bit cells has `VL_WORDS` rows. A tile with 64-bit cells has `VL_WORDS/2` rows. Two predicate masks decide which cells are updated, one for rows and one for columns. Masked-off cells keep their old value.

A command port takes four kinds of command: multiply-accumulate, clear a tile, read one row of a tile, and none. A sequencer handles each accepted command. It has the states IDLE, ACC (one tile row updated per cycle), CLEAR (one tile row cleared per cycle), READ (one cycle that presents read data) and FAULT (one cycle that signals an illegal mode). From IDLE, an accepted command moves it to ACC, CLEAR, READ or FAULT. ACC and CLEAR return to IDLE after the last row. READ and FAULT always return to IDLE after one cycle.

Top module: `opa_tile_acc`

## Requirements
- R1: A command is accepted only when `busy` is low and `cmd_valid` is high with `cmd_kind` not 0. The kind codes are 0 none, 1 multiply-accumulate, 2 clear, 3 read. Commands presented while `busy` is high, and kind 0, have no effect.
- R2: Mode 0 (byte, 4-way): cell (i,j) adds the sum of the four signed products of the bytes at equal positions in lane i of `vec_a` and lane j of `vec_b`. Lane k occupies bits 32k+31..32k.
- R3: Mode 1 (halfword into 32-bit, 2-way): cell (i,j) adds the sum of the two signed products of the 16-bit halves of lane i of `vec_a` and lane j of `vec_b`.
- R4: Mode 2 (halfword into 64-bit, 2-way): the tile has `VL_WORDS/2` rows and columns. Cell (i,j) adds the sign-extended 2-way halfword dot product of lane i of `vec_a` and lane j of `vec_b`, so only the low `VL_WORDS/2` lanes are read.
- R5: Accumulation wraps modulo 2^32 or 2^64 at the cell width, with no saturation.
- R6: Cell (i,j) changes only when bit i of `row_mask` and bit j of `col_mask` are both 1; otherwise it keeps its value.
- R7: Modes 3 to 7 on a multiply-accumulate are illegal. `err` goes high for exactly the cycle after acceptance and no tile changes.
- R8: A 32-bit tile t (index `cmd_tile[1:0]`) keeps row r on storage line 4r+t. A 64-bit tile t (index `cmd_tile`) keeps row r on line 8r+t. So the two views alias.
- R9: A clear command zeroes every row of the selected tile and touches no other line. `cmd_mode` 2 selects the 64-bit view and any other value selects the 32-bit view; the same rule applies to reads.
- R10: For a read, `rd_valid` is high for exactly the cycle after acceptance. In that cycle `rd_data` holds row `cmd_row` of the tile, with lane k of a 32-bit row in bits 32k+31..32k and cell k of a 64-bit row in bits 64k+63..64k.
- R11: `busy` rises the cycle after acceptance. It stays high for `VL_WORDS` cycles for a 32-bit multiply-accumulate or clear, `VL_WORDS/2` cycles for a 64-bit one, and one cycle for a read or an illegal command.
- R12: After reset all storage reads zero and `busy`, `err` and `rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_kind | input | 2 | 0 none, 1 multiply-accumulate, 2 clear, 3 read |
| cmd_mode | input | 3 | Arithmetic mode / view select |
| cmd_tile | input | 3 | Tile index |
| cmd_row | input | $clog2(VL_WORDS) | Row index for reads |
| vec_a | input | 32*VL_WORDS | Column vector (gives the rows) |
| vec_b | input | 32*VL_WORDS | Row vector (gives the columns) |
| row_mask | input | VL_WORDS | Row predicate |
| col_mask | input | VL_WORDS | Column predicate |
| busy | output | 1 | Sequencer not idle |
| err | output | 1 | Illegal-mode pulse |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32*VL_WORDS | Row read from the tile |

## Verification
The assertions check the handshake timing on every cycle. They cover `busy` rising after each accepted command, `err` lasting one cycle and only after an illegal mode, and `rd_valid` lasting one cycle after each read. They also check that no error follows a legal mode and that a cycle with no accepted command leaves the block idle. Only the bench's scenarios can show the arithmetic: the signed widening dot products, wrap-around, the merging masks, the aliasing between the 32-bit and 64-bit views, clears that spare other tiles, and commands dropped while busy. The bench shows these by reading rows back and comparing them with its own model.

// File: rtl/opa_pkg.sv
package opa_pkg;

    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_MAC  = 2'd1,
        K_ZERO = 2'd2,
        K_READ = 2'd3
    } cmd_kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ACC,
        S_CLEAR,
        S_READ,
        S_FAULT
    } seq_state_e;

    localparam logic [2:0] MODE_B4_W32 = 3'd0;
    localparam logic [2:0] MODE_H2_W32 = 3'd1;
    localparam logic [2:0] MODE_H2_W64 = 3'd2;

    localparam int NT32 = 4;
    localparam int NT64 = 8;

    // four signed byte products summed at 32 bits
    function automatic logic [31:0] dot_b4(input logic [31:0] a, input logic [31:0] b);
        logic signed [31:0] acc;
        acc = '0;
        for (int k = 0; k < 4; k++) begin
            acc += 32'($signed(a[8*k +: 8])) * 32'($signed(b[8*k +: 8]));
        end
        return acc;
    endfunction

    // two signed halfword products summed at 64 bits
    function automatic logic [63:0] dot_h2(input logic [31:0] a, input logic [31:0] b);
        logic signed [63:0] acc;
        acc = '0;
        for (int k = 0; k < 2; k++) begin
            acc += 64'($signed(a[16*k +: 16])) * 64'($signed(b[16*k +: 16]));
        end
        return acc;
    endfunction

    function automatic logic [31:0] dot_h2_n(input logic [31:0] a, input logic [31:0] b);
        return 32'(dot_h2(a, b));
    endfunction

endpackage

// File: rtl/opa_row_mac.sv
module opa_row_mac
    import opa_pkg::*;
#(
    parameter int VL_WORDS = 4,
    localparam int VW = VL_WORDS * 32,
    localparam int LANES64 = VL_WORDS / 2
) (
    input  logic [VW-1:0]       old_line,
    input  logic [31:0]         a_word,
    input  logic [VW-1:0]       b_vec,
    input  logic [2:0]          mode,
    input  logic                row_on,
    input  logic [VL_WORDS-1:0] col_mask,
    output logic [VW-1:0]       new_line
);

    logic [VW-1:0] line_n;
    logic [VW-1:0] line_w;

    // 32-bit cell view
    for (genvar j = 0; j < VL_WORDS; j++) begin : g_lane32
        logic [31:0] term;
        logic [31:0] old_c;
        assign old_c = old_line[32*j +: 32];
        assign term  = (mode == MODE_B4_W32) ? dot_b4(a_word, b_vec[32*j +: 32])
                                             : dot_h2_n(a_word, b_vec[32*j +: 32]);
        assign line_n[32*j +: 32] = (row_on && col_mask[j]) ? old_c + term : old_c;
    end

    // 64-bit cell view: column j uses lane j of the row vector
    for (genvar j = 0; j < LANES64; j++) begin : g_lane64
        logic [63:0] term;
        logic [63:0] old_c;
        assign old_c = old_line[64*j +: 64];
        assign term  = dot_h2(a_word, b_vec[32*j +: 32]);
        assign line_w[64*j +: 64] = (row_on && col_mask[j]) ? old_c + term : old_c;
    end

    assign new_line = (mode == MODE_H2_W64) ? line_w : line_n;

endmodule

// File: rtl/opa_seq_ctrl.sv
module opa_seq_ctrl
    import opa_pkg::*;
#(
    parameter int ROWS32 = 4,
    localparam int ROWS64 = ROWS32 / 2,
    localparam int STEP_W = $clog2(ROWS32)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  cmd_kind_e         cmd_kind,
    input  logic [2:0]        cmd_mode,
    output logic              load,
    output logic              wide,
    output logic [STEP_W-1:0] step,
    output logic              acc_we,
    output logic              clr_we,
    output logic              busy,
    output logic              err,
    output logic              rd_valid
);

    seq_state_e        state_q, state_d;
    logic [STEP_W-1:0] step_q, step_d;
    logic              wide_q, wide_d;
    logic              legal;
    logic [STEP_W-1:0] last;

    assign legal = (cmd_mode == MODE_B4_W32) || (cmd_mode == MODE_H2_W32) ||
                   (cmd_mode == MODE_H2_W64);
    assign last  = wide_q ? STEP_W'(ROWS64 - 1) : STEP_W'(ROWS32 - 1);

    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        wide_d  = wide_q;
        load    = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (cmd_valid && cmd_kind != K_NONE) begin
                    load   = 1'b1;
                    step_d = '0;
                    wide_d = (cmd_mode == MODE_H2_W64);
                    unique case (cmd_kind)
                        K_MAC:   state_d = legal ? S_ACC : S_FAULT;
                        K_ZERO:  state_d = S_CLEAR;
                        K_READ:  state_d = S_READ;
                        default: state_d = S_IDLE;
                    endcase
                end
            end
            S_ACC, S_CLEAR: begin
                if (step_q == last) begin
                    state_d = S_IDLE;
                end else begin
                    step_d = step_q + 1'b1;
                end
            end
            S_READ, S_FAULT: state_d = S_IDLE;
            default:         state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            step_q  <= '0;
            wide_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
            wide_q  <= wide_d;
        end
    end

    always_comb begin
        busy     = 1'b1;
        err      = 1'b0;
        rd_valid = 1'b0;
        acc_we   = 1'b0;
        clr_we   = 1'b0;
        unique case (state_q)
            S_IDLE:  busy     = 1'b0;
            S_ACC:   acc_we   = 1'b1;
            S_CLEAR: clr_we   = 1'b1;
            S_READ:  rd_valid = 1'b1;
            S_FAULT: err      = 1'b1;
            default: busy     = 1'b1;
        endcase
    end

    assign step = step_q;
    assign wide = wide_q;

endmodule

// File: rtl/opa_tile_acc.sv
module opa_tile_acc
    import opa_pkg::*;
#(
    parameter int VL_WORDS = 4,
    localparam int VW     = VL_WORDS * 32,
    localparam int LINES  = VL_WORDS * 4,
    localparam int LW     = $clog2(LINES),
    localparam int STEP_W = $clog2(VL_WORDS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_kind,
    input  logic [2:0]          cmd_mode,
    input  logic [2:0]          cmd_tile,
    input  logic [STEP_W-1:0]   cmd_row,
    input  logic [VW-1:0]       vec_a,
    input  logic [VW-1:0]       vec_b,
    input  logic [VL_WORDS-1:0] row_mask,
    input  logic [VL_WORDS-1:0] col_mask,
    output logic                busy,
    output logic                err,
    output logic                rd_valid,
    output logic [VW-1:0]       rd_data
);

    logic              load, wide, acc_we, clr_we;
    logic [STEP_W-1:0] step;

    logic [2:0]          mode_q;
    logic [2:0]          tile_q;
    logic [STEP_W-1:0]   row_q;
    logic [VW-1:0]       a_q, b_q;
    logic [VL_WORDS-1:0] rmask_q, cmask_q;

    logic [VW-1:0] za_q [LINES];
    logic [LW-1:0] addr;
    logic [VW-1:0] new_line;

    opa_seq_ctrl #(.ROWS32(VL_WORDS)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_kind (cmd_kind_e'(cmd_kind)),
        .cmd_mode (cmd_mode),
        .load     (load),
        .wide     (wide),
        .step     (step),
        .acc_we   (acc_we),
        .clr_we   (clr_we),
        .busy     (busy),
        .err      (err),
        .rd_valid (rd_valid)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= '0;
            tile_q  <= '0;
            row_q   <= '0;
            a_q     <= '0;
            b_q     <= '0;
            rmask_q <= '0;
            cmask_q <= '0;
        end else if (load) begin
            mode_q  <= cmd_mode;
            tile_q  <= cmd_tile;
            row_q   <= cmd_row;
            a_q     <= vec_a;
            b_q     <= vec_b;
            rmask_q <= row_mask;
            cmask_q <= col_mask;
        end
    end

    // interleaved line mapping shared by both tile views
    always_comb begin
        int r_sel;
        int ln;
        r_sel = rd_valid ? int'(row_q) : int'(step);
        ln    = wide ? (r_sel * NT64 + int'(tile_q))
                     : (r_sel * NT32 + int'(tile_q[1:0]));
        addr  = ln[LW-1:0];
    end

    opa_row_mac #(.VL_WORDS(VL_WORDS)) u_mac (
        .old_line(za_q[addr]),
        .a_word  (a_q[32*step +: 32]),
        .b_vec   (b_q),
        .mode    (mode_q),
        .row_on  (rmask_q[step]),
        .col_mask(cmask_q),
        .new_line(new_line)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < LINES; k++) begin
                za_q[k] <= '0;
            end
        end else if (acc_we) begin
            za_q[addr] <= new_line;
        end else if (clr_we) begin
            za_q[addr] <= '0;
        end
    end

    assign rd_data = rd_valid ? za_q[addr] : '0;

endmodule

// File: rtl/opa_tile_acc_chk.sv
module opa_tile_acc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [1:0] cmd_kind,
    input logic [2:0] cmd_mode,
    input logic       busy,
    input logic       err,
    input logic       rd_valid
);

    logic accept;
    assign accept = !busy && cmd_valid && (cmd_kind != 2'd0);

    p_accept_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);

    p_idle_stays_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !accept) |=> !busy);

    p_illegal_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_kind == 2'd1 && cmd_mode > 3'd2) |=> err);

    p_legal_no_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !(cmd_kind == 2'd1 && cmd_mode > 3'd2)) |=> !err);

    p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    p_err_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> busy);

    p_read_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_kind == 2'd3) |=> rd_valid);

    p_read_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> (!rd_valid && !busy));

endmodule

bind opa_tile_acc opa_tile_acc_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_kind (cmd_kind),
    .cmd_mode (cmd_mode),
    .busy     (busy),
    .err      (err),
    .rd_valid (rd_valid)
);

// File: tb/sim_opa_tile_acc.sv
module sim_opa_tile_acc;

    localparam int VL = 4;
    localparam int VW = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_kind = '0;
    logic [2:0]    cmd_mode = '0;
    logic [2:0]    cmd_tile = '0;
    logic [1:0]    cmd_row = '0;
    logic [VW-1:0] vec_a = '0;
    logic [VW-1:0] vec_b = '0;
    logic [VL-1:0] row_mask = '0;
    logic [VL-1:0] col_mask = '0;
    logic          busy, err, rd_valid;
    logic [VW-1:0] rd_data;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [VW-1:0] mdl [16];
    logic [VW-1:0] exp_q [$];
    string         tag_q [$];

    always #5 clk = ~clk;

    opa_tile_acc u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_mode(cmd_mode), .cmd_tile(cmd_tile), .cmd_row(cmd_row),
        .vec_a(vec_a), .vec_b(vec_b), .row_mask(row_mask), .col_mask(col_mask),
        .busy(busy), .err(err), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [VW-1:0] act,
                       input logic [VW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_b4(input logic [31:0] a, input logic [31:0] b);
        int s = 0;
        for (int k = 0; k < 4; k++) s += int'($signed(a[8*k +: 8])) * int'($signed(b[8*k +: 8]));
        return s;
    endfunction

    function automatic logic [63:0] ref_h2(input logic [31:0] a, input logic [31:0] b);
        longint s = 0;
        for (int k = 0; k < 2; k++) s += longint'($signed(a[16*k +: 16])) * longint'($signed(b[16*k +: 16]));
        return s;
    endfunction

    function automatic int line_of(input bit wide, input int tile, input int r);
        return wide ? (r * 8 + tile) : (r * 4 + (tile % 4));
    endfunction

    task automatic model_mac(input logic [2:0] m, input int tile, input logic [VW-1:0] a,
                             input logic [VW-1:0] b, input logic [3:0] rm, input logic [3:0] cm);
        if (m == 3'd2) begin
            for (int r = 0; r < 2; r++)
                for (int j = 0; j < 2; j++)
                    if (rm[r] && cm[j])
                        mdl[line_of(1, tile, r)][64*j +: 64] = mdl[line_of(1, tile, r)][64*j +: 64]
                                                              + ref_h2(a[32*r +: 32], b[32*j +: 32]);
        end else begin
            for (int r = 0; r < 4; r++)
                for (int j = 0; j < 4; j++)
                    if (rm[r] && cm[j]) begin
                        logic [63:0] h;
                        logic [31:0] t;
                        h = ref_h2(a[32*r +: 32], b[32*j +: 32]);
                        t = (m == 3'd0) ? ref_b4(a[32*r +: 32], b[32*j +: 32]) : h[31:0];
                        mdl[line_of(0, tile, r)][32*j +: 32] = mdl[line_of(0, tile, r)][32*j +: 32] + t;
                    end
        end
    endtask

    // driver: one command, expected read data pushed to the scoreboard queue
    task automatic do_cmd(input logic [1:0] k, input logic [2:0] m, input int tile, input int row,
                          input logic [VW-1:0] a, input logic [VW-1:0] b,
                          input logic [3:0] rm, input logic [3:0] cm,
                          input int exp_busy, input bit exp_err, input bit inject, input string tag);
        int n;
        bit wide;
        wide = (m == 3'd2);
        @(negedge clk);
        if (k == 2'd3) begin
            exp_q.push_back(mdl[line_of(wide, tile, row)]);
            tag_q.push_back(tag);
        end
        cmd_kind = k; cmd_mode = m; cmd_tile = 3'(tile); cmd_row = 2'(row);
        vec_a = a; vec_b = b; row_mask = rm; col_mask = cm;
        cmd_valid = 1'b1;
        @(negedge clk);
        chk(err == exp_err, {tag, " err flag"}, VW'(err), VW'(exp_err));
        if (inject) cmd_kind = 2'd3;
        else cmd_valid = 1'b0;
        n = 0;
        while (busy && n < 100) begin
            n++;
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        chk(n == exp_busy, {tag, " busy cycles"}, VW'(n), VW'(exp_busy));
        if (k == 2'd1 && !exp_err) model_mac(m, tile, a, b, rm, cm);
        if (k == 2'd2)
            for (int r = 0; r < (wide ? 2 : 4); r++) mdl[line_of(wide, tile, r)] = '0;
    endtask

    task automatic rd(input bit wide, input int tile, input int row, input string tag);
        do_cmd(2'd3, wide ? 3'd2 : 3'd0, tile, row, '0, '0, '0, '0, 1, 1'b0, 1'b0, tag);
    endtask

    // monitor: pops expected rows as the design presents them
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin : mon
            logic [VW-1:0] e;
            string t;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R1 unexpected read data", rd_data, '0);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(rd_data == e, t, rd_data, e);
            end
        end
    end

    localparam logic [VW-1:0] A1 = 128'h80_7F_FF_01_12_34_F0_0F_7F_7F_80_80_01_02_03_04;
    localparam logic [VW-1:0] B1 = 128'hFF_FE_FD_FC_80_01_7F_10_05_06_F7_08_C0_3F_22_99;
    localparam logic [VW-1:0] A2 = 128'h8000_7FFF_FFFF_0002_1234_EDCB_7FFF_7FFF;
    localparam logic [VW-1:0] B2 = 128'h0003_8000_7FFF_FFFE_8001_0100_ABCD_4321;
    localparam logic [VW-1:0] HM = {4{32'h8000_8000}};

    initial begin
        for (int k = 0; k < 16; k++) mdl[k] = '0;
        repeat (3) @(negedge clk);
        chk(!busy && !err && !rd_valid, "R12 outputs after reset",
            VW'({busy, err, rd_valid}), '0);
        rst_n = 1'b1;

        do_cmd(2'd0, 3'd0, 0, 0, A1, B1, 4'hF, 4'hF, 0, 1'b0, 1'b0, "R1 kind none");
        rd(0, 0, 0, "R12 storage zero");

        do_cmd(2'd1, 3'd0, 1, 0, A1, B1, 4'hF, 4'hF, 4, 1'b0, 1'b0, "R11 byte mac");
        for (int r = 0; r < 4; r++) rd(0, 1, r, "R2 byte 4-way row");
        do_cmd(2'd1, 3'd0, 1, 0, B1, A1, 4'hF, 4'hF, 4, 1'b0, 1'b0, "R2 second mac");
        rd(0, 1, 2, "R2 accumulate");

        do_cmd(2'd1, 3'd1, 2, 0, A2, B2, 4'b1010, 4'b0110, 4, 1'b0, 1'b0, "R3 halfword mac");
        for (int r = 0; r < 4; r++) rd(0, 2, r, "R6 masked halfword row");

        do_cmd(2'd1, 3'd2, 5, 0, A2, B2, 4'hF, 4'hF, 2, 1'b0, 1'b0, "R11 wide mac");
        rd(1, 5, 0, "R4 wide row 0");
        rd(1, 5, 1, "R4 wide row 1");
        rd(0, 1, 1, "R8 alias line 5");
        rd(0, 1, 3, "R8 alias line 13");

        do_cmd(2'd1, 3'd1, 3, 0, HM, HM, 4'hF, 4'hF, 4, 1'b0, 1'b0, "R5 wrap step 1");
        chk(mdl[line_of(0, 3, 0)][31:0] == 32'h8000_0000, "R5 model wrap value",
            VW'(mdl[line_of(0, 3, 0)][31:0]), VW'(32'h8000_0000));
        rd(0, 3, 0, "R5 after one wrap step");
        do_cmd(2'd1, 3'd1, 3, 0, HM, HM, 4'hF, 4'hF, 4, 1'b0, 1'b0, "R5 wrap step 2");
        rd(0, 3, 3, "R5 wrapped to zero");

        do_cmd(2'd1, 3'd3, 1, 0, A1, B1, 4'hF, 4'hF, 1, 1'b1, 1'b0, "R7 mode 3");
        do_cmd(2'd1, 3'd7, 2, 0, A1, B1, 4'hF, 4'hF, 1, 1'b1, 1'b0, "R7 mode 7");
        rd(0, 1, 0, "R7 tile 1 unchanged");
        rd(0, 2, 1, "R7 tile 2 unchanged");

        do_cmd(2'd1, 3'd0, 0, 0, A1, A1, 4'hF, 4'hF, 4, 1'b0, 1'b1, "R1 read while busy");
        rd(0, 0, 1, "R1 after dropped command");

        do_cmd(2'd2, 3'd0, 1, 0, '0, '0, '0, '0, 4, 1'b0, 1'b0, "R9 clear 32-bit tile");
        rd(0, 1, 0, "R9 cleared row 0");
        rd(0, 1, 3, "R9 cleared row 3");
        rd(0, 2, 1, "R9 other tile kept");
        do_cmd(2'd1, 3'd2, 6, 0, B2, A2, 4'hF, 4'hF, 2, 1'b0, 1'b0, "R4 wide tile 6");
        do_cmd(2'd2, 3'd2, 6, 0, '0, '0, '0, '0, 2, 1'b0, 1'b0, "R9 clear 64-bit tile");
        rd(0, 2, 1, "R9 line 6 cleared");
        rd(0, 3, 0, "R9 neighbour line kept");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R10 all reads answered", VW'(exp_q.size()), '0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule